// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller

This block gathers 96 level-sensitive interrupt inputs and drives one interrupt line to a processor. Software programs it through a 32-bit register bus with separate read and write strobes, using byte addresses that are word aligned. Each source has a mask bit and an 8-bit level register, and bits [7:2] of that register give the source's priority. While no interrupt is in service, the block picks the best eligible pending source and latches its number. It then raises its interrupt line and holds it there until software writes an acknowledge. After the acknowledge it starts the next selection.

Software finds the source to service by reading the active-number register. If the latched source stops being pending before the acknowledge, that register flags the interrupt as spurious. A soft reset returns every programmable register to its reset value, and a status bit shows when the reset has finished. The revision, autoidle, protection and idle registers are plain storage.

Top module: `level_irq_ctrl`

## Requirements
- R1: After reset, the following values hold. Every mask bit is 1 and every level register is 0. The threshold (0x68) reads 0xFF. Status (0x14) bit 0 reads 1. The revision register (0x00) reads 0x21, with the major nibble in [7:4] and the minor nibble in [3:0]. `irq_o` is low.
- R2: For bank n (0..2), a write to 0x88+0x20n clears every mask bit whose data bit is 1. A write to 0x8C+0x20n sets every mask bit whose data bit is 1. Data bits of 0 leave their mask bits unchanged. The bank's mask reads at 0x84+0x20n.
- R3: The pending register of bank n at 0x98+0x20n reads as the bank's inputs ANDed with the inverse of its mask.
- R4: `irq_o` rises on the clock edge after an eligible source is seen while no interrupt is in service. It stays high until a write to control (0x48) with bit 0 set. A control write with bit 0 clear has no effect.
- R5: The latched source is the eligible pending source with the smallest priority value, where priority is bits [7:2] of the level register at 0x100+4i. Among equal priorities the lowest index wins. Its number reads in bits [6:0] of 0x40.
- R6: A source is eligible only if its priority is strictly less than the threshold. A threshold of 0xFF disables this filter.
- R7: If the latched source is masked or drops its input before the acknowledge, bit 7 of 0x40 reads 1 from the following cycle. An acknowledge clears it.
- R8: On the edge after an acknowledge, `irq_o` is low. If eligible sources remain, `irq_o` rises again on the next edge with the new winner.
- R9: Writing system config (0x10) with bit 1 set starts a soft reset. Every register takes its R1 value and status bit 0 reads 0 for 4 cycles, then reads 1. Config bit 1 always reads 0.
- R10: Config bit 0 (autoidle), protection (0x4C) bit 0, idle (0x50) bits [1:0] and all 8 bits of each level register read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 96 | Level interrupt inputs, active high |
| addr | input | 12 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, captured on the rising edge |
| rd_en | input | 1 | Read strobe; rdata is zero when low |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
Register reads are combinational, so the bench samples them 1 ns after it drives the address, half a cycle clear of any edge. Register writes, the selection and acknowledges each take effect on one rising edge. The bench drives those at a falling edge and checks results at the next falling edge. A spurious flag appears one edge after the input drops or the mask is set, and the bench waits that one extra edge before it reads 0x40. Soft-reset completion is checked at exactly the third and fourth falling edges after the write returns, so both an early and a late completion would be caught.

// File: rtl/level_irq_ctrl.sv
module level_irq_ctrl #(
  parameter int NSRC     = 96,
  parameter int AW       = 12,
  parameter int SRST_CYC = 4,
  parameter logic [7:0] REV = 8'h21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            irq_o
);
  localparam int NB = NSRC / 32;
  localparam int IW = $clog2(NSRC);
  localparam int CW = $clog2(SRST_CYC + 1);

  logic [NSRC-1:0] mask, pend;
  logic [7:0]      lvl [NSRC];
  logic [7:0]      thr;
  logic            autoidle, prot, busy, spur, found;
  logic [1:0]      idle;
  logic [IW-1:0]   act, best;
  logic [5:0]      bp;
  logic [CW-1:0]   srcnt;
  logic [31:0]     rv;

  wire sr_go  = wr_en && addr == AW'(16) && wdata[1];
  wire ack_wr = wr_en && addr == AW'(72) && wdata[0];

  assign pend  = irq_in & ~mask;
  assign irq_o = busy;

  always_comb begin
    found = 1'b0;
    best  = '0;
    bp    = '1;
    for (int i = 0; i < NSRC; i++)
      if (pend[i] && (thr == 8'hFF || {2'b00, lvl[i][7:2]} < thr) &&
          (!found || lvl[i][7:2] < bp)) begin
        found = 1'b1;
        best  = IW'(i);
        bp    = lvl[i][7:2];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '1; thr <= 8'hFF; autoidle <= 1'b0; prot <= 1'b0; idle <= '0;
      busy <= 1'b0; spur <= 1'b0; act <= '0; srcnt <= '0;
      for (int i = 0; i < NSRC; i++) lvl[i] <= '0;
    end else if (sr_go) begin
      mask <= '1; thr <= 8'hFF; autoidle <= 1'b0; prot <= 1'b0; idle <= '0;
      busy <= 1'b0; spur <= 1'b0; act <= '0; srcnt <= CW'(SRST_CYC);
      for (int i = 0; i < NSRC; i++) lvl[i] <= '0;
    end else begin
      if (srcnt != '0) srcnt <= srcnt - 1'b1;
      if (wr_en) begin
        if (addr == AW'(16))  autoidle <= wdata[0];
        if (addr == AW'(76))  prot     <= wdata[0];
        if (addr == AW'(80))  idle     <= wdata[1:0];
        if (addr == AW'(104)) thr      <= wdata[7:0];
        for (int b = 0; b < NB; b++) begin
          if (addr == AW'(132 + 32*b)) mask[b*32 +: 32] <= wdata;
          if (addr == AW'(136 + 32*b)) mask[b*32 +: 32] <= mask[b*32 +: 32] & ~wdata;
          if (addr == AW'(140 + 32*b)) mask[b*32 +: 32] <= mask[b*32 +: 32] | wdata;
        end
        for (int i = 0; i < NSRC; i++)
          if (addr == AW'(256 + 4*i)) lvl[i] <= wdata[7:0];
      end
      if (ack_wr) begin
        busy <= 1'b0;
        spur <= 1'b0;
      end else if (!busy && found) begin
        busy <= 1'b1;
        act  <= best;
        spur <= 1'b0;
      end else if (busy && !pend[act]) begin
        spur <= 1'b1;
      end
    end
  end

  always_comb begin
    rv = '0;
    if (addr == AW'(0))   rv = {24'h0, REV};
    if (addr == AW'(16))  rv = {31'h0, autoidle};
    if (addr == AW'(20))  rv = {31'h0, srcnt == '0};
    if (addr == AW'(64))  rv = 32'({spur, act});
    if (addr == AW'(76))  rv = {31'h0, prot};
    if (addr == AW'(80))  rv = {30'h0, idle};
    if (addr == AW'(104)) rv = {24'h0, thr};
    for (int b = 0; b < NB; b++) begin
      if (addr == AW'(132 + 32*b)) rv = mask[b*32 +: 32];
      if (addr == AW'(152 + 32*b)) rv = pend[b*32 +: 32];
    end
    for (int i = 0; i < NSRC; i++)
      if (addr == AW'(256 + 4*i)) rv = {24'h0, lvl[i]};
  end
  assign rdata = rd_en ? rv : '0;

  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(ack_wr || sr_go));
  // R5
  grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(found) && $past(best) == act));
  // R6
  thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (found && thr != 8'hFF) |-> ({2'b00, lvl[best][7:2]} < thr));
  // R7
  spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_wr && !sr_go && !pend[act]) |=> spur);
  // R9
  srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_go |=> ((&mask) && thr == 8'hFF && !irq_o));
endmodule

// File: tb/sim_level_irq_ctrl.sv
module sim_level_irq_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [95:0] irq_in = '0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0, rdata, r;
  logic        irq_o;
  int checks = 0, fails = 0;

  logic [95:0] bmask;
  logic [7:0]  blvl [96];
  logic [7:0]  bthr;

  level_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = 12'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 12'(a); rd_en = 1'b1; #1; d = rdata; rd_en = 1'b0;
  endtask

  task automatic mclr(input int b, input logic [31:0] d);
    wr(136 + 32*b, d); bmask[b*32 +: 32] &= ~d;
  endtask
  task automatic mset(input int b, input logic [31:0] d);
    wr(140 + 32*b, d); bmask[b*32 +: 32] |= d;
  endtask
  task automatic setlvl(input int i, input logic [7:0] v);
    wr(256 + 4*i, {24'h0, v}); blvl[i] = v;
  endtask
  task automatic model_reset();
    bmask = '1; bthr = 8'hFF;
    for (int i = 0; i < 96; i++) blvl[i] = '0;
  endtask

  function automatic logic [7:0] exp_win(input logic [95:0] raw);
    logic f = 1'b0; logic [6:0] w = '0; logic [5:0] p = '1;
    for (int i = 0; i < 96; i++)
      if (raw[i] && !bmask[i] && (bthr == 8'hFF || {2'b0, blvl[i][7:2]} < bthr) &&
          (!f || blvl[i][7:2] < p)) begin
        f = 1'b1; w = 7'(i); p = blvl[i][7:2];
      end
    return {f, w};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] e;
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_o", {31'h0, irq_o}, 32'h0);
    rd(0, r);   chk("R1 revision", r, 32'h21);
    rd(20, r);  chk("R1 status", r, 32'h1);
    rd(132, r); chk("R1 mask0", r, 32'hFFFFFFFF);
    rd(196, r); chk("R1 mask2", r, 32'hFFFFFFFF);
    rd(104, r); chk("R1 threshold", r, 32'hFF);
    rd(256+4*95, r); chk("R1 level95", r, 32'h0);

    // R2 set/clear masking
    mclr(0, 32'h000000F0); rd(132, r); chk("R2 clear", r, 32'hFFFFFF0F);
    mset(0, 32'h00000010); rd(132, r); chk("R2 set", r, 32'hFFFFFF1F);
    mclr(1, 32'hFFFF0000); rd(164, r); chk("R2 clear bank1", r, 32'h0000FFFF);
    mclr(1, 32'h0);        rd(164, r); chk("R2 zero write", r, 32'h0000FFFF);

    // R3 pending view
    @(negedge clk); irq_in = {32'h12345678, 32'hFFFF0000, 32'h000000FF};
    #1;
    rd(152, r); chk("R3 pend0", r, irq_in[31:0] & ~bmask[31:0]);
    rd(184, r); chk("R3 pend1", r, irq_in[63:32] & ~bmask[63:32]);
    rd(216, r); chk("R3 pend2", r, irq_in[95:64] & ~bmask[95:64]);
    irq_in = '0;
    wr(72, 1);

    // R5 priority and tie order
    for (int b = 0; b < 3; b++) mclr(b, 32'hFFFFFFFF);
    setlvl(3, 8'h14); setlvl(70, 8'h14); setlvl(10, 8'h1C);
    irq_in[3] = 1'b1; irq_in[10] = 1'b1; irq_in[70] = 1'b1;
    @(negedge clk);
    chk("R4 irq rises", {31'h0, irq_o}, 32'h1);
    rd(64, r); chk("R5 tie lowest index", r, 32'd3);
    wr(72, 0);
    chk("R4 ack bit0 clear ignored", {31'h0, irq_o}, 32'h1);
    // R8 re-sort after acknowledge
    wr(72, 1);
    chk("R8 irq low after ack", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R8 irq again", {31'h0, irq_o}, 32'h1);
    rd(64, r); chk("R8 winner", r, 32'd3);

    // R7 spurious by input drop, then by mask
    irq_in[3] = 1'b0;
    @(negedge clk); @(negedge clk);
    rd(64, r); chk("R7 spurious drop", r, 32'h83);
    wr(72, 1); @(negedge clk);
    rd(64, r); chk("R5 next winner", r, 32'd70);
    mset(2, 32'h40); @(negedge clk);
    rd(64, r); chk("R7 spurious mask", r, 32'hC6);

    // R6 threshold
    irq_in = '0; wr(72, 1);
    mclr(2, 32'h40);
    wr(104, 5); bthr = 8'd5;
    setlvl(10, 8'h08);
    irq_in[10] = 1'b1; irq_in[70] = 1'b1;
    @(negedge clk);
    rd(64, r); chk("R6 threshold pick", r, 32'd10);
    irq_in = '0; wr(72, 1);
    wr(104, 2); bthr = 8'd2;
    irq_in[10] = 1'b1; irq_in[70] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 all filtered", {31'h0, irq_o}, 32'h0);
    irq_in = '0;
    wr(104, 32'hFF); bthr = 8'hFF;

    // R10 plain storage
    wr(16, 1);  rd(16, r); chk("R10 autoidle", r, 32'h1);
    wr(76, 1);  rd(76, r); chk("R10 protection", r, 32'h1);
    wr(80, 3);  rd(80, r); chk("R10 idle", r, 32'h3);
    setlvl(1, 8'hAB); rd(260, r); chk("R10 level", r, 32'hAB);

    // R9 soft reset
    irq_in[1] = 1'b1; @(negedge clk);
    chk("R9 busy before", {31'h0, irq_o}, 32'h1);
    wr(16, 2);
    irq_in = '0;
    model_reset();
    rd(20, r); chk("R9 status busy", r, 32'h0);
    chk("R9 irq cleared", {31'h0, irq_o}, 32'h0);
    @(negedge clk); @(negedge clk); @(negedge clk);
    rd(20, r); chk("R9 status at 3", r, 32'h0);
    @(negedge clk);
    rd(20, r); chk("R9 status done", r, 32'h1);
    rd(16, r); chk("R9 config cleared", r, 32'h0);
    rd(132, r); chk("R9 mask reset", r, 32'hFFFFFFFF);
    rd(260, r); chk("R9 level reset", r, 32'h0);
    rd(76, r); chk("R9 protection reset", r, 32'h0);

    // R5 R6 R3 random trials
    for (int t = 0; t < 40; t++) begin
      logic [95:0] raw;
      for (int k = 0; k < 4; k++) setlvl($urandom % 96, 8'($urandom));
      for (int b = 0; b < 3; b++) begin
        mclr(b, $urandom); mset(b, $urandom & $urandom);
      end
      if ($urandom % 2) begin bthr = 8'($urandom % 64); wr(104, {24'h0, bthr}); end
      else begin bthr = 8'hFF; wr(104, 32'hFF); end
      raw = {$urandom & $urandom, $urandom & $urandom, $urandom & $urandom};
      irq_in = raw;
      e = exp_win(raw);
      @(negedge clk);
      chk("R6 random irq", {31'h0, irq_o}, {31'h0, e[7]});
      if (e[7]) begin rd(64, r); chk("R5 random winner", r, {25'h0, e[6:0]}); end
      rd(184, r); chk("R3 random pend1", r, raw[63:32] & ~bmask[63:32]);
      irq_in = '0;
      wr(72, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule